// File: doc/BRIEF.md
# Local Serial Bus Clock and Frame-Sync Generator

This block derives the bit clock and the frame-sync pulse of a local serial bus by counting cycles of one fast master clock, nominally 65.536 MHz. A frame lasts 8192 master cycles (125 µs). The bit clock runs at 2.048, 4.096 or 8.192 MHz, or at twice the selected rate. The frame sync is one bit-clock period wide and sits at one of three places around the frame boundary. An optional 5-of-8 asymmetric clock shape is available at the fastest rate. Each output can be inverted separately.

The rate, sync position, double-rate and duty-shape selections are sampled only at a frame boundary. A change therefore never produces a short clock pulse or a partial frame. Polarity selections are not held for a frame and act on the next master cycle.

When the clock-fail input is raised, the serial-output enable drops. If the free-run enable is set and the active rate is 2.048 MHz, the clock and frame timing continue. Otherwise they freeze at their idle levels until the fail condition clears. The block has no streaming data path, so every pin is a plain level signal and no valid/ready handshake applies.

Top module: `lclk_fs_gen`

## Requirements
- R1: While rst_n is low, lclk, lfs, frame_strobe and so_en are all 0. The first rising clock edge after reset release starts a frame: frame_strobe is 1 in the cycle that follows that edge, and the selections present at that edge become active.
- R2: While running, a frame is 8192 master cycles long. frame_strobe is high for exactly one cycle per frame, in the cycle whose frame position is 0.
- R3: Bit-clock period in master cycles: rate_sel 00 gives 32, 01 gives 16, 10 gives 8, and 11 behaves as 00. dbl_rate=1 halves the period. In the normal shape the clock is high during the first half of each period, where the period position is the frame position modulo the period.
- R4: With period P and frame position n, the active-high sync depends on fs_pos. Code 00 (last) asserts it for n >= 8192-P. Code 01 (straddle) asserts it for n >= 8192-P/2 or n < P/2. Code 10 (first) asserts it for n < P.
- R5: fs_pos code 11 behaves exactly as code 00.
- R6: clk_inv inverts lclk and fs_inv inverts lfs. Each takes effect in the cycle after the edge that sees it, without waiting for a frame boundary.
- R7: The 5-of-8 shape takes effect only when all of these hold: duty58_en=1, rate_sel=10, dbl_rate=0, and bus_rate_sel is 00 or 01. In that shape the clock is high for period positions 0 to 4 and low for positions 5 to 7.
- R8: A change of rate_sel, fs_pos, dbl_rate, duty58_en or bus_rate_sel between frame boundaries has no effect until the next boundary.
- R9: With clk_fail=1, and free-run not permitted, the frame position freezes. lclk equals clk_inv, lfs equals fs_inv, and frame_strobe is 0.
- R10: so_en is the inverse of clk_fail, delayed by one cycle. With clk_fail=1, freerun_en=1 and an active rate of 2.048 MHz, lclk, lfs and frame_strobe continue exactly as when running normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominal 65.536 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Local data rate code |
| bus_rate_sel | input | 2 | Backplane data rate code, used to gate the 5-of-8 shape |
| fs_pos | input | 2 | Frame-sync position code |
| dbl_rate | input | 1 | Clock and sync at twice the data rate |
| duty58_en | input | 1 | Request for the 5-of-8 clock shape |
| clk_inv | input | 1 | Invert lclk |
| fs_inv | input | 1 | Invert lfs |
| clk_fail | input | 1 | Backplane clock failure indication |
| freerun_en | input | 1 | Permit free-running during clock failure |
| lclk | output | 1 | Local bit clock |
| lfs | output | 1 | Local frame sync |
| frame_strobe | output | 1 | One-cycle pulse on the first cycle of each frame |
| so_en | output | 1 | Serial data output enable |

## Verification
Every output is a register loaded from the next frame position and the next active selection. Each result is therefore due in the cycle that follows the rising edge at which the inputs were sampled, with no further delay. The bench holds its inputs stable across each rising edge and advances its own frame-position model once per edge, using those held inputs. It then compares all four outputs at the following falling edge, and only after that does it change any input. Selection changes are predicted one full frame late, because the model latches them only on its own wrap to position 0. Polarity changes are predicted in the very next cycle.

// File: rtl/lfg_pkg.sv
package lfg_pkg;

  typedef enum logic [1:0] {
    FS_LAST     = 2'b00,
    FS_STRADDLE = 2'b01,
    FS_FIRST    = 2'b10
  } fspos_e;

  localparam logic [1:0] RATE_SLOW = 2'd0;
  localparam logic [1:0] RATE_FAST = 2'd2;

  typedef struct packed {
    logic [1:0] rate;
    fspos_e     pos;
    logic       dbl;
    logic       duty;
  } lfg_cfg_t;

  localparam lfg_cfg_t CFG_RESET = '{rate: RATE_SLOW, pos: FS_LAST, dbl: 1'b0, duty: 1'b0};

endpackage

// File: rtl/lfg_cfg_latch.sv
module lfg_cfg_latch
  import lfg_pkg::*;
#(
  parameter bit HAS_DUTY = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] rate_req,
  input  logic [1:0] bus_rate,
  input  logic [1:0] pos_req,
  input  logic       dbl_req,
  input  logic       duty_req,
  output lfg_cfg_t   cfg_q,
  output lfg_cfg_t   cfg_nxt
);

  lfg_cfg_t dec;
  logic     duty_ok;

  generate
    if (HAS_DUTY) begin : g_duty
      assign duty_ok = duty_req && (rate_req == RATE_FAST) && !bus_rate[1] && !dbl_req;
    end else begin : g_noduty
      assign duty_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    dec.rate = (rate_req == 2'b11) ? RATE_SLOW : rate_req;
    dec.pos  = (pos_req == 2'b11) ? FS_LAST : fspos_e'(pos_req);
    dec.dbl  = dbl_req;
    dec.duty = duty_ok;
    cfg_nxt  = load ? dec : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_nxt;
  end

endmodule

// File: rtl/lfg_frame_cnt.sv
module lfg_frame_cnt #(
  parameter int unsigned FRAME_TICKS = 8192,
  localparam int unsigned CNT_W = $clog2(FRAME_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap_nxt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);

  always_comb begin
    cnt_nxt  = cnt_q;
    wrap_nxt = 1'b0;
    if (adv) begin
      if (cnt_q == LAST) begin
        cnt_nxt  = '0;
        wrap_nxt = 1'b1;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  // Reset parks on the last position so the first advance opens a frame.
  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/lfg_wave.sv
module lfg_wave
  import lfg_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 8192,
  parameter int unsigned BASE_LOG    = 5,
  localparam int unsigned CNT_W = $clog2(FRAME_TICKS)
) (
  input  logic [CNT_W-1:0] cnt,
  input  lfg_cfg_t         cfg,
  output logic             clk_raw,
  output logic             fs_raw
);

  localparam logic [CNT_W:0] FR = (CNT_W+1)'(FRAME_TICKS);

  logic [2:0]     pshift;
  logic [CNT_W:0] per, half, ph, pos;

  always_comb begin
    pshift = 3'(BASE_LOG) - {1'b0, cfg.rate} - {2'b00, cfg.dbl};
    per    = (CNT_W+1)'(1) << pshift;
    half   = per >> 1;
    pos    = {1'b0, cnt};
    ph     = pos & (per - 1'b1);
    clk_raw = cfg.duty ? (ph < (CNT_W+1)'(5)) : (ph < half);
    case (cfg.pos)
      FS_STRADDLE: fs_raw = (pos >= FR - half) || (pos < half);
      FS_FIRST:    fs_raw = (pos < per);
      default:     fs_raw = (pos >= FR - per);
    endcase
  end

endmodule

// File: rtl/lclk_fs_gen.sv
module lclk_fs_gen
  import lfg_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 8192,
  parameter int unsigned BASE_LOG    = 5,
  parameter bit          HAS_DUTY    = 1'b1,
  localparam int unsigned CNT_W = $clog2(FRAME_TICKS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic [1:0] bus_rate_sel,
  input  logic [1:0] fs_pos,
  input  logic       dbl_rate,
  input  logic       duty58_en,
  input  logic       clk_inv,
  input  logic       fs_inv,
  input  logic       clk_fail,
  input  logic       freerun_en,
  output logic       lclk,
  output logic       lfs,
  output logic       frame_strobe,
  output logic       so_en
);

  lfg_cfg_t         cfg_q, cfg_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             wrap_nxt, adv, clk_raw, fs_raw;

  assign adv = !clk_fail || (freerun_en && cfg_q.rate == RATE_SLOW);

  lfg_frame_cnt #(.FRAME_TICKS(FRAME_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap_nxt(wrap_nxt)
  );

  lfg_cfg_latch #(.HAS_DUTY(HAS_DUTY)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(wrap_nxt),
    .rate_req(rate_sel), .bus_rate(bus_rate_sel), .pos_req(fs_pos),
    .dbl_req(dbl_rate), .duty_req(duty58_en),
    .cfg_q(cfg_q), .cfg_nxt(cfg_nxt)
  );

  lfg_wave #(.FRAME_TICKS(FRAME_TICKS), .BASE_LOG(BASE_LOG)) u_wave (
    .cnt(cnt_nxt), .cfg(cfg_nxt), .clk_raw(clk_raw), .fs_raw(fs_raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lclk         <= 1'b0;
      lfs          <= 1'b0;
      frame_strobe <= 1'b0;
      so_en        <= 1'b0;
    end else begin
      lclk         <= (adv & clk_raw) ^ clk_inv;
      lfs          <= (adv & fs_raw) ^ fs_inv;
      frame_strobe <= wrap_nxt;
      so_en        <= !clk_fail;
    end
  end

endmodule

// File: rtl/lfg_chk.sv
module lfg_chk
  import lfg_pkg::*;
#(
  parameter int unsigned CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_fail,
  input logic             freerun_en,
  input logic             clk_inv,
  input logic             fs_inv,
  input logic             lclk,
  input logic             lfs,
  input logic             frame_strobe,
  input logic             so_en,
  input logic [CNT_W-1:0] cnt,
  input lfg_cfg_t         act_cfg
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe); // R2

  AST_SO_OFF_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fail |=> !so_en); // R10

  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fail && !freerun_en) |=> (lclk == $past(clk_inv) && lfs == $past(fs_inv) && !frame_strobe)); // R9

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fail && !freerun_en) |=> $stable(cnt)); // R9

  AST_FREERUN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fail && freerun_en && act_cfg.rate == RATE_SLOW) |=> (cnt != $past(cnt))); // R10

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |-> $stable(act_cfg)); // R8

  AST_DUTY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    act_cfg.duty |-> (act_cfg.rate == RATE_FAST && !act_cfg.dbl)); // R7

endmodule

bind lclk_fs_gen lfg_chk #(.CNT_W(CNT_W)) u_lfg_chk (
  .clk(clk), .rst_n(rst_n), .clk_fail(clk_fail), .freerun_en(freerun_en),
  .clk_inv(clk_inv), .fs_inv(fs_inv), .lclk(lclk), .lfs(lfs),
  .frame_strobe(frame_strobe), .so_en(so_en), .cnt(cnt_q), .act_cfg(cfg_q)
);

// File: tb/test_lclk_fs_gen.sv
module test_lclk_fs_gen;

  localparam int FRAME = 8192;
  localparam int WDOG  = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rate_sel = '0, bus_rate_sel = '0, fs_pos = '0;
  logic dbl_rate = 0, duty58_en = 0, clk_inv = 0, fs_inv = 0, clk_fail = 0, freerun_en = 0;
  logic lclk, lfs, frame_strobe, so_en;

  int n_chk = 0, n_err = 0, cycles = 0;

  // bench model state
  int m_cnt = FRAME - 1, m_rate = 0, m_pos = 0;
  bit m_dbl = 0, m_duty = 0;

  always #10 clk = ~clk;

  lclk_fs_gen i_lclk_fs_gen (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .bus_rate_sel(bus_rate_sel),
    .fs_pos(fs_pos), .dbl_rate(dbl_rate), .duty58_en(duty58_en), .clk_inv(clk_inv),
    .fs_inv(fs_inv), .clk_fail(clk_fail), .freerun_en(freerun_en),
    .lclk(lclk), .lfs(lfs), .frame_strobe(frame_strobe), .so_en(so_en)
  );

  function automatic int period(int rate, bit dbl);
    return 32 >> (rate + int'(dbl));
  endfunction

  function automatic bit exp_clk(int cnt, int rate, bit dbl, bit duty);
    int p = period(rate, dbl);
    int ph = cnt % p;
    return duty ? (ph < 5) : (ph < p / 2);
  endfunction

  function automatic bit exp_fs(int cnt, int rate, bit dbl, int pos);
    int p = period(rate, dbl);
    case (pos)
      1: return (cnt >= FRAME - p / 2) || (cnt < p / 2);
      2: return cnt < p;
      default: return cnt >= FRAME - p;
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // one master cycle: model follows the edge using inputs held across it
  task automatic tick();
    bit run, ck, fs, pend;
    string tc, tf;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    run = !clk_fail || (freerun_en && m_rate == 0);
    if (run) begin
      m_cnt = (m_cnt == FRAME - 1) ? 0 : m_cnt + 1;
      if (m_cnt == 0) begin
        m_rate = (rate_sel == 2'b11) ? 0 : int'(rate_sel);
        m_pos  = (fs_pos == 2'b11) ? 0 : int'(fs_pos);
        m_dbl  = dbl_rate;
        m_duty = duty58_en && rate_sel == 2'b10 && !bus_rate_sel[1] && !dbl_rate;
      end
    end
    ck = run && exp_clk(m_cnt, m_rate, m_dbl, m_duty);
    fs = run && exp_fs(m_cnt, m_rate, m_dbl, m_pos);
    pend = (((rate_sel == 2'b11) ? 0 : int'(rate_sel)) != m_rate) || dbl_rate != m_dbl;
    if (!run)          tc = "R9";
    else if (clk_fail) tc = "R10";
    else if (pend)     tc = "R8";
    else if (clk_inv)  tc = "R6";
    else if (m_duty)   tc = "R7";
    else               tc = "R3";
    if (!run)                tf = "R9";
    else if (fs_pos == 2'b11) tf = "R5";
    else if (fs_inv)          tf = "R6";
    else                      tf = "R4";
    chk(lclk, ck ^ clk_inv, tc, "lclk");
    chk(lfs, fs ^ fs_inv, tf, "lfs");
    chk(frame_strobe, run && m_cnt == 0, "R2", "frame_strobe");
    chk(so_en, !clk_fail, "R10", "so_en");
  endtask

  // select a configuration, wait for it to be latched, then run a frame body
  task automatic frame(input int rate, input int pos, input bit dbl, input bit duty,
                       input int bus, input int fail_len, input bit fr);
    rate_sel = 2'(rate); fs_pos = 2'(pos); dbl_rate = dbl; duty58_en = duty;
    bus_rate_sel = 2'(bus);
    do tick(); while (!(frame_strobe === 1'b1 && m_cnt == 0));
    for (int i = 0; i < 6000; i++) begin
      tick();
      if ($urandom_range(0, 499) == 0) clk_inv = ~clk_inv;
      if ($urandom_range(0, 499) == 0) fs_inv  = ~fs_inv;
      if (i == 1500) begin  // R8: mid-frame junk selection, restored before the boundary
        rate_sel = ~rate_sel; dbl_rate = ~dbl_rate; fs_pos = 2'($urandom_range(0, 3));
        duty58_en = ~duty58_en;
      end
      if (i == 2500) begin
        rate_sel = 2'(rate); fs_pos = 2'(pos); dbl_rate = dbl; duty58_en = duty;
      end
      if (i == 4000 && fail_len > 0) begin clk_fail = 1; freerun_en = fr; end
      if (i == 4000 + fail_len) begin clk_fail = 0; freerun_en = 0; end
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    clk_inv = 1; fs_inv = 1; clk_fail = 1;
    repeat (4) @(negedge clk);
    chk(lclk, 1'b0, "R1", "lclk in reset");
    chk(lfs, 1'b0, "R1", "lfs in reset");
    chk(frame_strobe, 1'b0, "R1", "frame_strobe in reset");
    chk(so_en, 1'b0, "R1", "so_en in reset");
    clk_inv = 0; fs_inv = 0; clk_fail = 0;
    rate_sel = 2'b01; fs_pos = 2'b10;
    rst_n = 1;
    tick();
    chk(frame_strobe, 1'b1, "R1", "first frame strobe");
    chk(lfs, 1'b1, "R1", "first-period sync from selection at release");
    // directed corner cases
    frame(0, 0, 0, 0, 0, 0, 0);
    frame(1, 1, 0, 0, 0, 0, 0);
    frame(2, 2, 0, 0, 0, 0, 0);
    frame(3, 3, 0, 0, 0, 0, 0);   // reserved codes
    frame(2, 1, 1, 0, 0, 0, 0);   // fastest: period 4, straddle
    frame(2, 0, 0, 1, 0, 0, 0);   // 5-of-8 shape active
    frame(2, 2, 0, 1, 2, 0, 0);   // blocked by backplane rate
    frame(2, 0, 1, 1, 1, 0, 0);   // blocked by double rate
    frame(1, 1, 0, 1, 1, 0, 0);   // blocked by local rate
    frame(0, 1, 0, 0, 0, 60, 1);  // free-run
    frame(2, 0, 0, 0, 0, 40, 1);  // free-run refused at fast rate
    frame(0, 2, 1, 0, 0, 50, 0);  // plain halt
    // constrained random frames
    for (int f = 0; f < 8; f++) begin
      frame($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), $urandom_range(0, 3),
            ($urandom_range(0, 2) == 0) ? $urandom_range(1, 64) : 0,
            1'($urandom_range(0, 1)));
    end
    finish_run();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule